// File: doc/BRIEF.md
# Configuration Request Route Selector

This block sits between a host-side configuration access engine and a root port's link transmit path. For each configuration request it decides where the request goes. The request may go to the root port's own bridge registers. It may go out on the link as a Type 0 request for the device directly below the port. Otherwise it goes out as a Type 1 request that a downstream bridge forwards. The decision compares the request's bus and device numbers with a local bus number and a local device number held in a status register.

The root bus and the secondary bus share a single local bus number. Only the local device number separates the two. A request whose bus and device both match the local values reaches the bridge. A request that matches the bus but not the device goes downstream as Type 0. Software normally keeps the local device at 1. A point-to-point secondary bus carries only device 0, so the bridge never hides a real device. Changing the secondary bus number then only means rewriting the local bus field.

Each field of the status register has its own load strobe, so either field can be changed without disturbing the other. The status register also records a link-down flag. While that flag is set, any request routed to the link completes locally instead of being sent. The result for each request is held in a one-entry output stage with a valid/ready handshake.

Top module: `cfg_type_router`

## Requirements
- R1: After reset the status word reads 0x0001_0001: local bus 0 in bits 15:8, local device 1 in bits 20:16, and the link-down flag set in bit 0. No result is valid.
- R2: A pulse on `setBus` loads `newBus` into bits 15:8 at the next edge and leaves bits 20:16 unchanged. A pulse on `setDev` loads `newDev` into bits 20:16 and leaves bits 15:8 unchanged. All other status bits read zero.
- R3: An accepted request whose bus and device both equal the local values produces route code 0 (bridge registers).
- R4: An accepted request whose bus equals the local bus and whose device differs from the local device produces route code 1 (Type 0 on the link).
- R5: An accepted request whose bus differs from the local bus produces route code 2 (Type 1 on the link).
- R6: The result address is formed as follows:
  - bit 31 is set and bits 30:28 are zero;
  - register bits 9:6 are placed in bits 27:24;
  - bus in bits 23:16, device in bits 15:11 and function in bits 10:8;
  - register bits 5:0 are placed in bits 7:2, and bits 1:0 are zero.
- R7: When the link-down flag is set at acceptance and the route is 1 or 2, `rspDrop` is 1. `rspData` is then all ones for a read and zero for a write. Route 0 is never dropped.
- R8: When a request is not dropped, `rspDrop` is 0, `rspWrite` follows the request, and `rspData` carries the write data for writes and zero for reads.
- R9: `reqReady` equals `!rspValid || rspReady`. `rspValid` rises at the edge that accepts a request. While `rspValid` is high and `rspReady` is low, every result output holds.
- R10: Status bit 0 takes the value of `linkDownIn` one edge later. Routing uses the local values and the flag as they stand before the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| linkDownIn | input | 1 | Link-down indication, sampled every cycle |
| setBus | input | 1 | Load strobe for the local bus field |
| newBus | input | 8 | New local bus number |
| setDev | input | 1 | Load strobe for the local device field |
| newDev | input | 5 | New local device number |
| statusWord | output | 32 | Status register: bus 15:8, device 20:16, link-down bit 0 |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqBus | input | 8 | Target bus |
| reqDev | input | 5 | Target device |
| reqFunc | input | 3 | Target function |
| reqReg | input | 10 | Target dword register index |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqData | input | 32 | Write data |
| rspValid | output | 1 | Result valid |
| rspReady | input | 1 | Result consumed when high with rspValid |
| rspRoute | output | 2 | 0 bridge, 1 Type 0, 2 Type 1 |
| rspAddr | output | 32 | Formed configuration address |
| rspWrite | output | 1 | Request direction |
| rspData | output | 32 | Write data, or all ones for a dropped read |
| rspDrop | output | 1 | Completed locally because the link is down |

## Verification
Every result field, including the route, the address and the drop decision, belongs to the request accepted at one rising edge and is due at the falling edge that follows it. A field load or a new link-down value shows in the status word one edge after the strobe or input is presented. The bench drives inputs just after a falling edge and compares all outputs at the next falling edge. Its reference model advances on each rising edge, so each check falls at the end of the cycle in which the result is due, and again on every cycle that a stalled result is held.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  typedef enum logic [1:0] {
    ROUTE_BRIDGE = 2'd0,
    ROUTE_TYPE0  = 2'd1,
    ROUTE_TYPE1  = 2'd2
  } route_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRsp;
    logic setBus;
    logic setDev;
  } strobe_t;

endpackage

// File: rtl/cfg_route_ctrl.sv
module cfg_route_ctrl
  import cfg_route_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    rspReady,
  input  logic    setBusIn,
  input  logic    setDevIn,
  output logic    reqReady,
  output logic    rspValid,
  output strobe_t strobe
);

  logic accept;

  assign reqReady = !rspValid || rspReady;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else if (accept) begin
      rspValid <= 1'b1;
    end else if (rspReady) begin
      rspValid <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadRsp = accept;
    strobe.setBus  = setBusIn;
    strobe.setDev  = setDevIn;
  end

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid); // R9

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid); // R9

endmodule

// File: rtl/cfg_route_dp.sv
module cfg_route_dp
  import cfg_route_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int REG_W  = 10,
  parameter int DATA_W = 32,
  parameter int RESET_BUS = 0,
  parameter int RESET_DEV = 1,
  localparam int REG_LO_W = 6,
  localparam int ADDR_W   = 4 + (REG_W - REG_LO_W) + BUS_W + DEV_W + FUNC_W + REG_LO_W + 2,
  localparam int STS_W    = 32,
  localparam int BUS_POS  = 8,
  localparam int DEV_POS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              linkDownIn,
  input  logic [BUS_W-1:0]  newBus,
  input  logic [DEV_W-1:0]  newDev,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [REG_W-1:0]  reqReg,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  output logic [STS_W-1:0]  statusWord,
  output route_e            rspRoute,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspWrite,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDrop
);

  logic [BUS_W-1:0]  localBus;
  logic [DEV_W-1:0]  localDev;
  logic              linkDown;

  logic              busHit;
  logic              devHit;
  route_e            nextRoute;
  logic              nextDrop;
  logic [DATA_W-1:0] nextData;
  logic [ADDR_W-1:0] nextAddr;

  // status register, each field loaded on its own strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localBus <= BUS_W'(RESET_BUS);
      localDev <= DEV_W'(RESET_DEV);
      linkDown <= 1'b1;
    end else begin
      linkDown <= linkDownIn;
      if (strobe.setBus) localBus <= newBus;
      if (strobe.setDev) localDev <= newDev;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = linkDown;
    statusWord[BUS_POS +: BUS_W] = localBus;
    statusWord[DEV_POS +: DEV_W] = localDev;
  end

  // route decision
  assign busHit = (reqBus == localBus);
  assign devHit = (reqDev == localDev);

  always_comb begin
    if (!busHit)     nextRoute = ROUTE_TYPE1;
    else if (devHit) nextRoute = ROUTE_BRIDGE;
    else             nextRoute = ROUTE_TYPE0;
  end

  assign nextDrop = (nextRoute != ROUTE_BRIDGE) && linkDown;

  always_comb begin
    if (nextDrop)      nextData = reqWrite ? '0 : '1;
    else if (reqWrite) nextData = reqData;
    else               nextData = '0;
  end

  assign nextAddr = {1'b1, 3'b000, reqReg[REG_W-1:REG_LO_W], reqBus, reqDev,
                     reqFunc, reqReg[REG_LO_W-1:0], 2'b00};

  // result stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRoute <= ROUTE_BRIDGE;
      rspAddr  <= '0;
      rspWrite <= 1'b0;
      rspData  <= '0;
      rspDrop  <= 1'b0;
    end else if (strobe.loadRsp) begin
      rspRoute <= nextRoute;
      rspAddr  <= nextAddr;
      rspWrite <= reqWrite;
      rspData  <= nextData;
      rspDrop  <= nextDrop;
    end
  end

  AST_BUS_KEEPS_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setBus && !strobe.setDev) |=> $stable(localDev)); // R2

  AST_DEV_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setDev && !strobe.setBus) |=> $stable(localBus)); // R2

  AST_LINK_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (linkDown == $past(linkDownIn))); // R10

  AST_BRIDGE_NEVER_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    rspDrop |-> (rspRoute != ROUTE_BRIDGE)); // R7

endmodule

// File: rtl/cfg_type_router.sv
module cfg_type_router
  import cfg_route_pkg::*;
#(
  parameter int RESET_BUS = 0,
  parameter int RESET_DEV = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        linkDownIn,
  input  logic        setBus,
  input  logic [7:0]  newBus,
  input  logic        setDev,
  input  logic [4:0]  newDev,
  output logic [31:0] statusWord,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [7:0]  reqBus,
  input  logic [4:0]  reqDev,
  input  logic [2:0]  reqFunc,
  input  logic [9:0]  reqReg,
  input  logic        reqWrite,
  input  logic [31:0] reqData,
  output logic        rspValid,
  input  logic        rspReady,
  output logic [1:0]  rspRoute,
  output logic [31:0] rspAddr,
  output logic        rspWrite,
  output logic [31:0] rspData,
  output logic        rspDrop
);

  strobe_t strobe;
  route_e  routeQ;

  cfg_route_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .setBusIn (setBus),
    .setDevIn (setDev),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  cfg_route_dp #(
    .BUS_W     (8),
    .DEV_W     (5),
    .FUNC_W    (3),
    .REG_W     (10),
    .DATA_W    (32),
    .RESET_BUS (RESET_BUS),
    .RESET_DEV (RESET_DEV)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .linkDownIn (linkDownIn),
    .newBus     (newBus),
    .newDev     (newDev),
    .reqBus     (reqBus),
    .reqDev     (reqDev),
    .reqFunc    (reqFunc),
    .reqReg     (reqReg),
    .reqWrite   (reqWrite),
    .reqData    (reqData),
    .statusWord (statusWord),
    .rspRoute   (routeQ),
    .rspAddr    (rspAddr),
    .rspWrite   (rspWrite),
    .rspData    (rspData),
    .rspDrop    (rspDrop)
  );

  assign rspRoute = routeQ;

  AST_STALL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspAddr) && $stable(rspRoute) &&
                                 $stable(rspData) && $stable(rspDrop))); // R9

endmodule

// File: tb/test_cfg_type_router.sv
module test_cfg_type_router;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 6000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        linkDownIn;
  logic        setBus;
  logic [7:0]  newBus;
  logic        setDev;
  logic [4:0]  newDev;
  logic [31:0] statusWord;
  logic        reqValid;
  logic        reqReady;
  logic [7:0]  reqBus;
  logic [4:0]  reqDev;
  logic [2:0]  reqFunc;
  logic [9:0]  reqReg;
  logic        reqWrite;
  logic [31:0] reqData;
  logic        rspValid;
  logic        rspReady;
  logic [1:0]  rspRoute;
  logic [31:0] rspAddr;
  logic        rspWrite;
  logic [31:0] rspData;
  logic        rspDrop;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit running  = 1'b0;
  int routeSeen[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_type_router i_cfg_type_router (
    .clk(clk), .rstN(rstN), .linkDownIn(linkDownIn),
    .setBus(setBus), .newBus(newBus), .setDev(setDev), .newDev(newDev),
    .statusWord(statusWord),
    .reqValid(reqValid), .reqReady(reqReady), .reqBus(reqBus), .reqDev(reqDev),
    .reqFunc(reqFunc), .reqReg(reqReg), .reqWrite(reqWrite), .reqData(reqData),
    .rspValid(rspValid), .rspReady(rspReady), .rspRoute(rspRoute),
    .rspAddr(rspAddr), .rspWrite(rspWrite), .rspData(rspData), .rspDrop(rspDrop)
  );

  // behavioural reference model
  int          mBus, mDev;
  bit          mLd, mValid, mWrite, mDrop;
  int          mRoute;
  logic [31:0] mAddr, mData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBus = 0; mDev = 1; mLd = 1; mValid = 0;
      mRoute = 0; mAddr = 0; mData = 0; mWrite = 0; mDrop = 0;
    end else begin
      if (reqValid && (!mValid || rspReady)) begin
        if (int'(reqBus) != mBus)      mRoute = 2;
        else if (int'(reqDev) == mDev) mRoute = 0;
        else                           mRoute = 1;
        mDrop  = (mRoute != 0) && mLd;
        mWrite = reqWrite;
        mAddr  = 32'h8000_0000 | (32'(reqReg >> 6) << 24) | (32'(reqBus) << 16)
               | (32'(reqDev) << 11) | (32'(reqFunc) << 8) | (32'(reqReg & 10'h3f) << 2);
        if (mDrop)         mData = reqWrite ? 32'h0 : 32'hffff_ffff;
        else if (reqWrite) mData = reqData;
        else               mData = 32'h0;
        mValid = 1;
      end else if (rspReady) begin
        mValid = 0;
      end
      mLd = linkDownIn;
      if (setBus) mBus = int'(newBus);
      if (setDev) mDev = int'(newDev);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    return (32'(mDev) << 16) | (32'(mBus) << 8) | 32'(mLd);
  endfunction

  always @(negedge clk) begin
    if (running) begin
      check(statusWord == expStatus(), "R2/R10", "status", statusWord, expStatus());
      check(statusWord[0] == mLd, "R10", "link flag", 32'(statusWord[0]), 32'(mLd));
      check(reqReady == (!mValid || rspReady), "R9", "reqReady",
            32'(reqReady), 32'(!mValid || rspReady));
      check(rspValid == mValid, "R9", "rspValid", 32'(rspValid), 32'(mValid));
      if (mValid) begin
        routeSeen[mRoute]++;
        case (mRoute)
          0: check(rspRoute == 2'd0, "R3", "route", 32'(rspRoute), 32'(mRoute));
          1: check(rspRoute == 2'd1, "R4", "route", 32'(rspRoute), 32'(mRoute));
          default: check(rspRoute == 2'd2, "R5", "route", 32'(rspRoute), 32'(mRoute));
        endcase
        check(rspAddr == mAddr, "R6", "address", rspAddr, mAddr);
        if (mDrop) begin
          check(rspDrop == 1'b1, "R7", "drop", 32'(rspDrop), 32'(mDrop));
          check(rspData == mData, "R7", "dropped data", rspData, mData);
        end else begin
          check(rspDrop == 1'b0, "R8", "drop", 32'(rspDrop), 32'(mDrop));
          check(rspData == mData, "R8", "data", rspData, mData);
          check(rspWrite == mWrite, "R8", "write", 32'(rspWrite), 32'(mWrite));
        end
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; linkDownIn = 1'b1; setBus = 0; newBus = 0; setDev = 0; newDev = 0;
    reqValid = 0; reqBus = 0; reqDev = 0; reqFunc = 0; reqReg = 0; reqWrite = 0;
    reqData = 0; rspReady = 1;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(statusWord == 32'h0001_0001, "R1", "status after reset", statusWord, 32'h0001_0001);
    check(rspValid == 1'b0, "R1", "rspValid after reset", 32'(rspValid), 32'h0);
    running = 1'b1;
    // directed: default map sends bus 0 device 1 to the bridge, device 0 to Type 0
    #1 reqValid = 1; reqBus = 0; reqDev = 1; reqFunc = 0; reqReg = 10'h3c1; reqWrite = 0;
    @(negedge clk);
    #1 reqDev = 0; reqWrite = 1; reqData = 32'hcafe_0001;
    @(negedge clk);
    #1 reqBus = 8'h07; reqDev = 5'h1f; reqFunc = 3'h7; reqReg = 10'h3ff;
    @(negedge clk);
    for (int i = 0; i < RUN_CYCLES; i++) begin
      #1;
      if (i > RUN_CYCLES/4) linkDownIn = ($urandom_range(0, 39) == 0) ? ~linkDownIn : linkDownIn;
      setBus   = ($urandom_range(0, 15) == 0);
      newBus   = 8'($urandom_range(0, 3));
      setDev   = ($urandom_range(0, 15) == 0);
      newDev   = 5'($urandom_range(0, 2));
      reqValid = ($urandom_range(0, 3) != 0);
      reqBus   = ($urandom_range(0, 1) == 0) ? 8'(mBus) : 8'($urandom_range(0, 255));
      reqDev   = ($urandom_range(0, 1) == 0) ? 5'(mDev) : 5'($urandom_range(0, 31));
      reqFunc  = 3'($urandom_range(0, 7));
      reqReg   = 10'($urandom_range(0, 1023));
      reqWrite = $urandom_range(0, 1) == 1;
      reqData  = $urandom;
      rspReady = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end
    check(routeSeen[0] > 0 && routeSeen[1] > 0 && routeSeen[2] > 0, "R3/R4/R5",
          "all routes exercised", 32'(routeSeen[0] > 0 && routeSeen[1] > 0 && routeSeen[2] > 0), 32'h1);
    finishRun();
  end

endmodule